// File: doc/BRIEF.md
# Dual-Converter Serial Readout Logic

This block is the digital control side of a dual 12-bit converter that samples two channels at the same instant. An active-low select line frames each readout. When select falls, the block latches the input-pair choice and the range/coding choice, and captures one result from each of two converter models. Each model is supplied as a pair of 12-bit input words, one word per input.

Both results are then shifted out at the same time on two serial lines, most significant bit first. Each line advances one bit per falling edge of the serial clock. A frame is 16 bits: a zero, three status bits, then the 12-bit result. If select stays low for a second frame, each line carries the other converter's frame, so one serial port can collect both results.

The coding is fixed at the select edge. It flips to the other format if the range input has changed level by the eighth serial clock falling edge. The serial clock and select are sampled by the block's own clock, and each output is modelled as a data bit plus an output enable.

Top module: `dsr_readout`

## Requirements
- R1: A falling edge of `cs_n`, seen at a rising edge of `clk`, latches `chan_sel` and `range_sel` and captures both results. From the following `clk` cycle both enables are 1 and both lines show the first frame bit.
- R2: A frame is 16 bits, sent in this order: position 0 is 0; position 1 is the latched channel select; position 2 is the latched range value; position 3 is the converter id (0 for A, 1 for B); positions 4 to 15 are the 12-bit result, MSB first.
- R3: The bit position advances by exactly one per falling edge of `sclk` (a 1 then 0 sample on `clk`). It holds while `sclk` does not fall.
- R4: During the first 16 bits, `dout_a` carries converter A's frame and `dout_b` carries converter B's frame, both at the same time.
- R5: While `cs_n` stays low, the next 16 falling edges carry the other converter's frame on each line: B's frame on `dout_a` and A's frame on `dout_b`.
- R6: `chan_sel` = 0 at the select edge picks input 1 of both converters (`conv_a1`, `conv_b1`). `chan_sel` = 1 picks input 2 (`conv_a2`, `conv_b2`).
- R7: `range_sel` = 0 at the select edge gives straight binary. `range_sel` = 1 gives two's complement, which is the straight binary result with its MSB inverted.
- R8: If `range_sel` at the eighth `sclk` falling edge differs from the latched value, the coding flips for all result bits sent after that edge. The status range bit keeps the latched value.
- R9: One `clk` cycle after `cs_n` is sampled high, both enables are 0. While an enable is 0, its data line is 0.
- R10: After 32 falling edges with `cs_n` still low, both enables go to 0. Further `sclk` edges do not re-enable them.
- R11: Changes to `chan_sel` and to the converter words after the select edge do not alter the frames being sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; samples `cs_n` and `sclk` |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Active-low select; its falling edge starts a conversion |
| sclk | input | 1 | Serial clock; output bits advance on its falling edge |
| chan_sel | input | 1 | Input-pair select, latched at the select edge |
| range_sel | input | 1 | Range/coding select, latched at the select edge and checked again at the eighth edge |
| conv_a1 | input | 12 | Converter A model, input 1 result |
| conv_a2 | input | 12 | Converter A model, input 2 result |
| conv_b1 | input | 12 | Converter B model, input 1 result |
| conv_b2 | input | 12 | Converter B model, input 2 result |
| dout_a | output | 1 | Serial data, line A |
| doe_a | output | 1 | Output enable, line A (0 = high impedance) |
| dout_b | output | 1 | Serial data, line B |
| doe_b | output | 1 | Output enable, line B (0 = high impedance) |

## Verification
The assertions take for granted that `cs_n` and `sclk` are already synchronous to `clk`. They also assume each level of `sclk` lasts at least one `clk` cycle, so that every serial falling edge is seen as a 1 followed by a 0. The bench drives every input on the falling edge of `clk` and holds each `sclk` level for a full cycle. It raises `cs_n` only between serial edges, so each detected edge in the block matches one intended edge and no edge lands in a reset cycle.

// File: rtl/dsr_pkg.sv
package dsr_pkg;
   // number of header bits ahead of the result: zero, channel, range, id
   localparam int HDR_W   = 4;
   localparam int LANES   = 2;
   localparam int ID_POS  = 3;
endpackage

// File: rtl/dsr_edge_det.sv
module dsr_edge_det #(
   parameter int        N        = 2,
   parameter logic [N-1:0] IDLE  = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] sig,
   output logic [N-1:0] fall
);
   logic [N-1:0] sig_q;

   always_ff @(posedge clk) begin
      if (!rst_n) sig_q <= IDLE;
      else        sig_q <= sig;
   end

   for (genvar i = 0; i < N; i++) begin : g_fall
      assign fall[i] = sig_q[i] & ~sig[i];
   end
endmodule

// File: rtl/dsr_seq.sv
module dsr_seq #(
   parameter int DATA_W     = 12,
   parameter int FRAME_W    = 16,
   parameter int NUM_FRAMES = 2,
   parameter int FLIP_EDGE  = 8,
   parameter int CNT_W      = 6
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   cs_low,
   input  logic                   cs_fall,
   input  logic                   sclk_fall,
   input  logic                   chan_sel,
   input  logic                   range_sel,
   input  logic [DATA_W-1:0]      conv_a1,
   input  logic [DATA_W-1:0]      conv_a2,
   input  logic [DATA_W-1:0]      conv_b1,
   input  logic [DATA_W-1:0]      conv_b2,
   output logic                   active_q,
   output logic [CNT_W-1:0]       cnt_q,
   output logic                   chan_q,
   output logic                   range_q,
   output logic                   coding_q,
   output logic [1:0][DATA_W-1:0] res_q
);
   localparam int TOTAL = FRAME_W * NUM_FRAMES;
   localparam logic [CNT_W-1:0] CNT_END  = CNT_W'(TOTAL);
   localparam logic [CNT_W-1:0] CNT_FLIP = CNT_W'(FLIP_EDGE - 1);

   wire step = sclk_fall && active_q && (cnt_q < CNT_END);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         cnt_q    <= '0;
         chan_q   <= 1'b0;
         range_q  <= 1'b0;
         coding_q <= 1'b0;
         res_q    <= '0;
      end else if (cs_fall) begin
         active_q <= 1'b1;
         cnt_q    <= '0;
         chan_q   <= chan_sel;
         range_q  <= range_sel;
         coding_q <= range_sel;
         res_q[0] <= chan_sel ? conv_a2 : conv_a1;
         res_q[1] <= chan_sel ? conv_b2 : conv_b1;
      end else if (!cs_low) begin
         active_q <= 1'b0;
      end else if (step) begin
         cnt_q <= cnt_q + CNT_W'(1);
         if (cnt_q == CNT_FLIP && range_sel != range_q)
            coding_q <= ~coding_q;
      end
   end

   // R3: the position only moves on a serial falling edge or a restart
   a_r3_cnt_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (!cs_fall && !sclk_fall) |=> $stable(cnt_q));

   // R8: coding only changes at a restart or at the eighth edge
   a_r8_flip_point: assert property (@(posedge clk) disable iff (!rst_n)
      (!cs_fall && !(sclk_fall && active_q && cnt_q == CNT_FLIP))
      |=> $stable(coding_q));
endmodule

// File: rtl/dsr_lane.sv
module dsr_lane #(
   parameter int DATA_W     = 12,
   parameter int FRAME_W    = 16,
   parameter int NUM_FRAMES = 2,
   parameter int CNT_W      = 6,
   parameter bit LANE       = 1'b0
) (
   input  logic                   active,
   input  logic [CNT_W-1:0]       cnt,
   input  logic                   chan,
   input  logic                   rng,
   input  logic                   coding,
   input  logic [1:0][DATA_W-1:0] res,
   output logic                   dout,
   output logic                   oe
);
   localparam int TOTAL = FRAME_W * NUM_FRAMES;
   localparam int IDX_W = $clog2(FRAME_W);

   logic             second;
   logic [CNT_W-1:0] pos;
   logic [CNT_W-1:0] bit_idx;
   logic             id;
   logic [DATA_W-1:0] data;
   logic [FRAME_W-1:0] word;

   if (NUM_FRAMES == 2) begin : g_chain
      assign second = (cnt >= CNT_W'(FRAME_W));
   end else begin : g_single
      assign second = 1'b0;
   end

   assign pos     = second ? cnt - CNT_W'(FRAME_W) : cnt;
   assign bit_idx = CNT_W'(FRAME_W - 1) - pos;
   assign id      = LANE ^ second;
   assign data    = res[id] ^ {coding, {(DATA_W-1){1'b0}}};
   assign word    = {1'b0, chan, rng, id, data};
   assign oe      = active && (cnt < CNT_W'(TOTAL));
   assign dout    = oe & word[bit_idx[IDX_W-1:0]];
endmodule

// File: rtl/dsr_readout.sv
module dsr_readout #(
   parameter int DATA_W     = 12,
   parameter int NUM_FRAMES = 2,
   parameter int FLIP_EDGE  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_n,
   input  logic              sclk,
   input  logic              chan_sel,
   input  logic              range_sel,
   input  logic [DATA_W-1:0] conv_a1,
   input  logic [DATA_W-1:0] conv_a2,
   input  logic [DATA_W-1:0] conv_b1,
   input  logic [DATA_W-1:0] conv_b2,
   output logic              dout_a,
   output logic              doe_a,
   output logic              dout_b,
   output logic              doe_b
);
   import dsr_pkg::*;

   localparam int FRAME_W = DATA_W + HDR_W;
   localparam int TOTAL   = FRAME_W * NUM_FRAMES;
   localparam int CNT_W   = $clog2(TOTAL + 1);

   initial begin
      if (DATA_W < 2)
         $error("DATA_W must be at least 2");
      if (NUM_FRAMES < 1 || NUM_FRAMES > 2)
         $error("NUM_FRAMES must be 1 or 2");
      if (FLIP_EDGE < 1 || FLIP_EDGE > TOTAL)
         $error("FLIP_EDGE out of range");
   end

   logic [1:0] falls;
   logic       cs_fall, sclk_fall;
   logic       active, chan_q, range_q, coding_q;
   logic [CNT_W-1:0] cnt;
   logic [1:0][DATA_W-1:0] res;
   logic [LANES-1:0] lane_d, lane_oe;

   dsr_edge_det #(.N(2), .IDLE(2'b01)) u_edge (
      .clk (clk), .rst_n (rst_n),
      .sig ({sclk, cs_n}), .fall (falls)
   );
   assign cs_fall   = falls[0];
   assign sclk_fall = falls[1];

   dsr_seq #(
      .DATA_W (DATA_W), .FRAME_W (FRAME_W), .NUM_FRAMES (NUM_FRAMES),
      .FLIP_EDGE (FLIP_EDGE), .CNT_W (CNT_W)
   ) u_seq (
      .clk (clk), .rst_n (rst_n), .cs_low (~cs_n), .cs_fall (cs_fall),
      .sclk_fall (sclk_fall), .chan_sel (chan_sel), .range_sel (range_sel),
      .conv_a1 (conv_a1), .conv_a2 (conv_a2),
      .conv_b1 (conv_b1), .conv_b2 (conv_b2),
      .active_q (active), .cnt_q (cnt), .chan_q (chan_q),
      .range_q (range_q), .coding_q (coding_q), .res_q (res)
   );

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      dsr_lane #(
         .DATA_W (DATA_W), .FRAME_W (FRAME_W), .NUM_FRAMES (NUM_FRAMES),
         .CNT_W (CNT_W), .LANE (1'(l))
      ) u_lane (
         .active (active), .cnt (cnt), .chan (chan_q), .rng (range_q),
         .coding (coding_q), .res (res),
         .dout (lane_d[l]), .oe (lane_oe[l])
      );
   end

   assign dout_a = lane_d[0];
   assign doe_a  = lane_oe[0];
   assign dout_b = lane_d[1];
   assign doe_b  = lane_oe[1];

   // R1: a select edge starts both lines with the leading zero
   a_r1_leading_zero: assert property (@(posedge clk) disable iff (!rst_n)
      cs_fall |=> (doe_a && doe_b && !dout_a && !dout_b));

   // R9: a deselected block drives nothing
   a_r9_deselect_off: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |=> (!doe_a && !doe_b));

   // R4: both lines are framed together
   a_r4_lanes_in_step: assert property (@(posedge clk) disable iff (!rst_n)
      doe_a == doe_b);
endmodule

// File: tb/dsr_readout_tb.sv
module dsr_readout_tb;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cs_n = 1'b1, sclk = 1'b0, chan_sel = 1'b0, range_sel = 1'b0;
   logic [11:0] conv_a1 = '0, conv_a2 = '0, conv_b1 = '0, conv_b2 = '0;
   logic dout_a, doe_a, dout_b, doe_b;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   dsr_readout u_dut (
      .clk (clk), .rst_n (rst_n), .cs_n (cs_n), .sclk (sclk),
      .chan_sel (chan_sel), .range_sel (range_sel),
      .conv_a1 (conv_a1), .conv_a2 (conv_a2),
      .conv_b1 (conv_b1), .conv_b2 (conv_b2),
      .dout_a (dout_a), .doe_a (doe_a), .dout_b (dout_b), .doe_b (doe_b)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   // expected frame per R2/R7: zero, chan, range, id, result with coding
   function automatic logic [15:0] frame(input logic ch, input logic rg,
         input logic id, input logic [11:0] raw, input logic twos);
      logic [11:0] v;
      v = raw;
      if (twos) v[11] = ~v[11];
      return {1'b0, ch, rg, id, v};
   endfunction

   task automatic tick();
      @(negedge clk) sclk = 1'b1;
      @(negedge clk) sclk = 1'b0;
      @(negedge clk);
   endtask

   task automatic start(input logic ch, input logic rg);
      @(negedge clk) begin cs_n = 1'b0; chan_sel = ch; range_sel = rg; end
      @(negedge clk);
   endtask

   task automatic stop();
      @(negedge clk) cs_n = 1'b1;
      @(negedge clk);
      chk("R9 doe_a off", 32'(doe_a), 0);
      chk("R9 doe_b off", 32'(doe_b), 0);
   endtask

   // reads 32 bits on both lines, then checks the lines are released
   task automatic read_chain(input logic [15:0] a0, input logic [15:0] a1,
         input logic [15:0] b0, input logic [15:0] b1, input string tag);
      logic [31:0] ea, eb, ga, gb;
      logic oe_ok;
      ea = {a0, a1}; eb = {b0, b1}; ga = '0; gb = '0; oe_ok = 1'b1;
      for (int i = 0; i < 32; i++) begin
         ga[31-i] = dout_a; gb[31-i] = dout_b;
         if (!(doe_a && doe_b)) oe_ok = 1'b0;
         tick();
      end
      chk({tag, " R4 R5 line A stream"}, ga, ea);
      chk({tag, " R4 R5 line B stream"}, gb, eb);
      chk({tag, " R3 enables held"}, 32'(oe_ok), 1);
      chk({tag, " R10 released after 32"}, {30'b0, doe_a, doe_b}, 0);
      tick();
      chk({tag, " R10 extra edge ignored"}, {30'b0, doe_a, doe_b}, 0);
   endtask

   task automatic t_reset();
      chk("R9 reset enables", {30'b0, doe_a, doe_b}, 0);
      chk("R9 reset data", {30'b0, dout_a, dout_b}, 0);
   endtask

   task automatic t_binary_ch1();
      conv_a1 = 12'hA5C; conv_a2 = 12'h123; conv_b1 = 12'h3F0; conv_b2 = 12'h456;
      start(1'b0, 1'b0);
      chk("R1 first bit zero", {30'b0, dout_a, dout_b}, 0);
      // R11: disturb inputs after the select edge
      chan_sel = 1'b1; conv_a1 = 12'h000; conv_b1 = 12'hFFF;
      read_chain(frame(0, 0, 0, 12'hA5C, 0), frame(0, 0, 1, 12'h3F0, 0),
                 frame(0, 0, 1, 12'h3F0, 0), frame(0, 0, 0, 12'hA5C, 0), "R6 R11 ch1");
      stop();
   endtask

   task automatic t_twos_ch2();
      conv_a2 = 12'h7E1; conv_b2 = 12'h802;
      start(1'b1, 1'b1);
      read_chain(frame(1, 1, 0, 12'h7E1, 1), frame(1, 1, 1, 12'h802, 1),
                 frame(1, 1, 1, 12'h802, 1), frame(1, 1, 0, 12'h7E1, 1), "R6 R7 ch2");
      stop();
   endtask

   task automatic t_flip();
      conv_a1 = 12'hC33; conv_b1 = 12'h0F0;
      start(1'b0, 1'b0);
      range_sel = 1'b1;
      // first-frame MSB leaves before the eighth edge; the chained frame is flipped
      read_chain(frame(0, 0, 0, 12'hC33, 0), frame(0, 0, 1, 12'h0F0, 1),
                 frame(0, 0, 1, 12'h0F0, 0), frame(0, 0, 0, 12'hC33, 1), "R8 flip");
      stop();
      range_sel = 1'b0;
   endtask

   task automatic t_hold_and_abort();
      conv_a1 = 12'hFFF; conv_b1 = 12'h000;
      start(1'b0, 1'b0);
      for (int i = 0; i < 5; i++) tick();
      // position 5 is result bit 10: A=1, B=0
      repeat (4) @(negedge clk);
      chk("R3 hold A", 32'(dout_a), 1);
      chk("R3 hold B", 32'(dout_b), 0);
      tick();
      chk("R3 one step A", 32'(dout_a), 1);
      stop();
      start(1'b0, 1'b0);
      chk("R1 restart enables", {30'b0, doe_a, doe_b}, 2'b11);
      chk("R1 restart zero", {30'b0, dout_a, dout_b}, 0);
      tick();
      chk("R2 channel bit", {30'b0, dout_a, dout_b}, 0);
      tick(); tick();
      chk("R2 id bit", {30'b0, dout_a, dout_b}, 2'b01);
      stop();
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_binary_ch1();
      t_twos_ch2();
      t_flip();
      t_hold_and_abort();
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule